// File: doc/BRIEF.md
# Release-on-readout bus interrupt requester

This block raises an interrupt on behalf of a backplane slave whose data leaves through an output FIFO. Software programs one 16-bit configuration word that carries a request level, a condition-select bit and an 8-bit vector byte. The block watches the FIFO's empty and half-full flags. While the chosen condition holds, it pulls low the one active-low request line whose number equals the programmed level.

When the bus master runs an acknowledge cycle for that level while the request is up, the block answers on the next clock with a hit strobe and the vector byte on data bits 7..0. The acknowledge does not clear the request. The line goes high again only after readout has removed the condition: the FIFO is drained to empty, or it drops below half full. If the condition comes back later, the request is raised again. Level 0 switches request generation off.

Arbitration wiring, bus drivers and the FIFO itself are outside the block. The FIFO flags, an acknowledge strobe and the acknowledged level arrive as inputs.

Top module: `irq_requester`

## Requirements
- R1: While `rst_n` is low at a clock edge, the configuration goes to level 0, condition select 0 and vector 0x00. After that edge, `cfg_rdata` reads 0x0F00, all of `irq_n` are high and `ack_hit` is low.
- R2: A clock edge with `cfg_wr` high loads the level from `cfg_wdata[15:13]`, the condition select from `cfg_wdata[12]` and the vector from `cfg_wdata[7:0]`. From the next cycle, `cfg_rdata` returns these fields in the same positions, with bits 11..8 always reading 1.
- R3: With condition select 0, the request is raised at the first edge where `fifo_half` is high. A FIFO that is not empty but has `fifo_half` low raises no request.
- R4: With condition select 1, the request is raised at the first edge where `fifo_empty` is low, whatever the state of `fifo_half`.
- R5: At most one bit of `irq_n[7:1]` is low at any time. When the request is up, the low bit is `irq_n[L]`, where L is the programmed level. With level 0, no line is ever driven low.
- R6: The request is withdrawn at the first edge where the selected condition is false: `fifo_half` low in half-full mode, or `fifo_empty` high in not-empty mode.
- R7: If `iack_stb` is high at an edge, `iack_level` equals the programmed level and the request is up, then in the following cycle `ack_hit` is 1 and `ack_data` carries the vector byte.
- R8: An acknowledge with a different level, with level 0 programmed, or while the request is down gives `ack_hit` 0 and `ack_data` 0x00 in the following cycle.
- R9: An acknowledge cycle does not withdraw the request. The line stays low while the condition holds.
- R10: After a withdrawal, the request is raised again at the first edge where the selected condition is true again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_wr | input | 1 | Write strobe for the configuration word |
| cfg_wdata | input | 16 | Configuration write data: level [15:13], select [12], vector [7:0] |
| cfg_rdata | output | 16 | Configuration readback, bits 11..8 read 1 |
| fifo_empty | input | 1 | FIFO empty flag |
| fifo_half | input | 1 | FIFO at or above half full |
| iack_stb | input | 1 | Acknowledge cycle in progress |
| iack_level | input | 3 | Level being acknowledged |
| irq_n | output | 7 | Active-low request lines, bit k is level k (bits 7..1) |
| ack_hit | output | 1 | This block answers the acknowledge (one cycle after the strobe) |
| ack_data | output | 8 | Vector byte for the acknowledge, 0 when not answering |

## Verification
The bench holds the request up through an acknowledge. A design that cleared the request on the acknowledge, as a classic acknowledge-release interrupter does, would let the line go high while the FIFO is still half full.

In half-full mode the bench offers a non-empty but below-half FIFO. A design that wired the select bit backwards would raise a request there. In not-empty mode it drops `fifo_half` while data remains, and a design with the same mix-up would withdraw the request.

The bench acknowledges at a wrong level and while the request is down, and expects silence. A design that decoded only the level would put its vector on the bus for another requester. It also sweeps all seven levels to catch an off-by-one line decode, programs level 0 with data waiting to catch a design that drives a phantom line, and resets while a request is up.

// File: rtl/irq_req_pkg.sv
`timescale 1ns/1ps
// Shared widths, field positions and types for the interrupt requester.
// Assumes a 16-bit configuration word whose field positions are fixed,
// because software decodes them.
package irq_req_pkg;
    localparam int LVL_W   = 3;
    localparam int ID_W    = 8;
    localparam int REG_W   = 16;
    localparam int N_LINES = (1 << LVL_W) - 1;
    localparam int LVL_LSB = REG_W - LVL_W;
    localparam int SEL_BIT = LVL_LSB - 1;
    localparam int FILL_W  = SEL_BIT - ID_W;

    typedef enum logic {
        COND_HALF   = 1'b0,
        COND_NEMPTY = 1'b1
    } cond_sel_e;

    typedef struct packed {
        logic [LVL_W-1:0] level;
        cond_sel_e        sel;
        logic [ID_W-1:0]  vec;
    } irq_cfg_t;
endpackage

// File: rtl/irq_cfg_reg.sv
`timescale 1ns/1ps
// Holds the programmed level, condition select and vector byte, and forms
// the readback word. Assumes a write strobe that lasts one clock. The bits
// between the select bit and the vector byte are not stored and read as one.
module irq_cfg_reg
    import irq_req_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wdata,
    output irq_cfg_t         cfg,
    output logic [REG_W-1:0] rdata
);
    irq_cfg_t cfg_q;

    // Load the fields on a write; clear level, select and vector on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '{level: '0, sel: COND_HALF, vec: '0};
        end else if (wr_en) begin
            cfg_q.level <= wdata[REG_W-1:LVL_LSB];
            cfg_q.sel   <= cond_sel_e'(wdata[SEL_BIT]);
            cfg_q.vec   <= wdata[ID_W-1:0];
        end
    end

    // Pack the readback word with the unstored bits forced high.
    always_comb begin
        rdata = {cfg_q.level, cfg_q.sel, {FILL_W{1'b1}}, cfg_q.vec};
    end

    assign cfg = cfg_q;

    // R2
    cfg_level_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (cfg.level == $past(wdata[REG_W-1:LVL_LSB])) && (cfg.vec == $past(wdata[ID_W-1:0])));
    // R2
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(cfg));
endmodule

// File: rtl/irq_req_ctl.sv
`timescale 1ns/1ps
// Decides whether the request is up. The request follows the selected FIFO
// condition with one register stage, so it is raised and withdrawn only by
// the FIFO flags, never by an acknowledge. Assumes the flags are synchronous.
module irq_req_ctl
    import irq_req_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  irq_cfg_t cfg,
    input  logic     fifo_empty,
    input  logic     fifo_half,
    output logic     req
);
    logic cond;
    logic req_q;

    // Pick the condition named by the select bit.
    always_comb begin
        unique case (cfg.sel)
            COND_HALF:   cond = fifo_half;
            COND_NEMPTY: cond = !fifo_empty;
            default:     cond = 1'b0;
        endcase
    end

    // Register the request; level 0 keeps it down.
    always_ff @(posedge clk) begin
        if (!rst_n) req_q <= 1'b0;
        else        req_q <= cond && (cfg.level != '0);
    end

    assign req = req_q;

    // R3
    raise_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.sel == COND_HALF && fifo_half && cfg.level != '0) |=> req);
    // R4
    raise_nempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.sel == COND_NEMPTY && !fifo_empty && cfg.level != '0) |=> req);
    // R6
    release_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.sel == COND_HALF && !fifo_half) |=> !req);
    // R6
    release_nempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.sel == COND_NEMPTY && fifo_empty) |=> !req);
    // R5
    level0_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.level == '0) |=> !req);
endmodule

// File: rtl/irq_line_drv.sv
`timescale 1ns/1ps
// Turns the request and level into one active-low line per level. Line k is
// low only while the request is up and the level equals k. Assumes the
// request and level come from registers. The clock and reset serve only the
// checks.
module irq_line_drv
    import irq_req_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req,
    input  logic [LVL_W-1:0] level,
    output logic [N_LINES:1] irq_n
);
    // One decoder per request line.
    for (genvar k = 1; k <= N_LINES; k++) begin : g_line
        assign irq_n[k] = !(req && (level == LVL_W'(k)));
    end

    // R5
    one_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~irq_n));
    // R5
    level0_lines_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (level == '0) |-> (&irq_n));
endmodule

// File: rtl/irq_ack_resp.sv
`timescale 1ns/1ps
// Answers an acknowledge cycle. The block answers only when the
// acknowledged level equals its own nonzero level and its request is up.
// It then presents the vector byte for one cycle, one clock after the
// strobe. Data is zero whenever it does not answer.
module irq_ack_resp
    import irq_req_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  irq_cfg_t         cfg,
    input  logic             req,
    input  logic             iack_stb,
    input  logic [LVL_W-1:0] iack_level,
    output logic             hit,
    output logic [ID_W-1:0]  data
);
    logic match;
    logic hit_q;
    logic [ID_W-1:0] data_q;

    // Decide whether this acknowledge belongs to this requester.
    always_comb begin
        match = iack_stb && req && (iack_level == cfg.level) && (cfg.level != '0);
    end

    // Register the answer and the vector byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hit_q  <= 1'b0;
            data_q <= '0;
        end else begin
            hit_q  <= match;
            data_q <= match ? cfg.vec : '0;
        end
    end

    assign hit  = hit_q;
    assign data = data_q;

    // R7
    hit_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> ($past(iack_stb) && $past(req)));
    // R8
    quiet_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |-> (data == '0));
    // R8
    wrong_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (iack_stb && iack_level != cfg.level) |=> !hit);
endmodule

// File: rtl/irq_requester.sv
`timescale 1ns/1ps
// Top of the release-on-readout interrupt requester. The configuration
// register feeds the request controller, the line decoder and the
// acknowledge responder. Assumes all inputs are synchronous to clk and
// that the FIFO flags reflect reads made through the slave's data path.
module irq_requester
    import irq_req_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr,
    input  logic [REG_W-1:0] cfg_wdata,
    output logic [REG_W-1:0] cfg_rdata,
    input  logic             fifo_empty,
    input  logic             fifo_half,
    input  logic             iack_stb,
    input  logic [LVL_W-1:0] iack_level,
    output logic [N_LINES:1] irq_n,
    output logic             ack_hit,
    output logic [ID_W-1:0]  ack_data
);
    irq_cfg_t cfg;
    logic     req;

    irq_cfg_reg u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (cfg_wr),
        .wdata (cfg_wdata),
        .cfg   (cfg),
        .rdata (cfg_rdata)
    );

    irq_req_ctl u_ctl (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg        (cfg),
        .fifo_empty (fifo_empty),
        .fifo_half  (fifo_half),
        .req        (req)
    );

    irq_line_drv u_lines (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (req),
        .level (cfg.level),
        .irq_n (irq_n)
    );

    irq_ack_resp u_ack (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg        (cfg),
        .req        (req),
        .iack_stb   (iack_stb),
        .iack_level (iack_level),
        .hit        (ack_hit),
        .data       (ack_data)
    );

    // R9
    ack_keeps_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_hit && cfg.sel == COND_HALF && fifo_half && !cfg_wr) |=> req);
endmodule

// File: tb/sim_irq_requester.sv
`timescale 1ns/1ps
module sim_irq_requester;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [15:0] cfg_wdata = '0;
    logic [15:0] cfg_rdata;
    logic        fifo_empty = 1'b1;
    logic        fifo_half = 1'b0;
    logic        iack_stb = 1'b0;
    logic [2:0]  iack_level = '0;
    logic [7:1]  irq_n;
    logic        ack_hit;
    logic [7:0]  ack_data;

    int n_run  = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    irq_requester u0 (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .fifo_empty(fifo_empty), .fifo_half(fifo_half),
        .iack_stb(iack_stb), .iack_level(iack_level), .irq_n(irq_n),
        .ack_hit(ack_hit), .ack_data(ack_data)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    function automatic logic [6:0] lines_exp(input int lvl, input bit on);
        if (on && lvl != 0) return ~(7'b1 << (lvl - 1));
        return 7'h7F;
    endfunction

    // Advance one edge, then settle at the falling edge.
    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic write_cfg(input logic [15:0] v);
        cfg_wr = 1'b1; cfg_wdata = v;
        tick();
        cfg_wr = 1'b0;
    endtask

    task automatic ack(input logic [2:0] lvl);
        iack_stb = 1'b1; iack_level = lvl;
        tick();
        iack_stb = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 readback", cfg_rdata, 16'h0F00);
        chk("R1 lines", irq_n, 7'h7F);
        chk("R1 hit", ack_hit, 1'b0);
    endtask

    task automatic t_fields();
        write_cfg(16'hB03C);
        chk("R2 readback fill ones", cfg_rdata, 16'hBF3C);
        write_cfg(16'h0000);
        chk("R2 readback cleared", cfg_rdata, 16'h0F00);
    endtask

    task automatic t_half_mode();
        // level 3, select 0 (half full), vector 0x5A
        fifo_empty = 1'b1; fifo_half = 1'b0;
        write_cfg(16'h605A);
        fifo_empty = 1'b0; tick();
        chk("R3 not-empty alone no request", irq_n, lines_exp(3, 0));
        fifo_half = 1'b1; tick();
        chk("R3 half raises line 3", irq_n, lines_exp(3, 1));
        ack(3'd3);
        chk("R7 hit", ack_hit, 1'b1);
        chk("R7 vector", ack_data, 8'h5A);
        chk("R9 request kept after ack", irq_n, lines_exp(3, 1));
        tick();
        chk("R7 hit one cycle", ack_hit, 1'b0);
        ack(3'd2);
        chk("R8 wrong level hit", ack_hit, 1'b0);
        chk("R8 wrong level data", ack_data, 8'h00);
        fifo_half = 1'b0; tick();
        chk("R6 release below half", irq_n, lines_exp(3, 0));
        ack(3'd3);
        chk("R8 ack while released", ack_hit, 1'b0);
        fifo_half = 1'b1; tick();
        chk("R10 re-raise", irq_n, lines_exp(3, 1));
        fifo_half = 1'b0; fifo_empty = 1'b1; tick();
    endtask

    task automatic t_nempty_mode();
        // level 7, select 1 (not empty), vector 0xC4
        write_cfg(16'hF0C4);
        chk("R4 empty no request", irq_n, lines_exp(7, 0));
        fifo_empty = 1'b0; tick();
        chk("R4 not empty raises line 7", irq_n, lines_exp(7, 1));
        fifo_half = 1'b1; tick();
        fifo_half = 1'b0; tick();
        chk("R4 half drop keeps request", irq_n, lines_exp(7, 1));
        ack(3'd7);
        chk("R7 vector level 7", ack_data, 8'hC4);
        fifo_empty = 1'b1; tick();
        chk("R6 release on empty", irq_n, lines_exp(7, 0));
        fifo_empty = 1'b0; tick();
        chk("R10 re-raise not empty", irq_n, lines_exp(7, 1));
        fifo_empty = 1'b1; tick();
    endtask

    task automatic t_levels();
        fifo_empty = 1'b0;
        write_cfg(16'h1099);
        chk("R5 level 0 no line", irq_n, 7'h7F);
        ack(3'd0);
        chk("R8 level 0 no hit", ack_hit, 1'b0);
        for (int l = 1; l <= 7; l++) begin
            write_cfg({l[2:0], 1'b1, 4'h0, 8'h11});
            tick();
            chk($sformatf("R5 line for level %0d", l), irq_n, lines_exp(l, 1));
        end
    endtask

    task automatic t_reset_mid();
        chk("R1 pre-reset active", irq_n, lines_exp(7, 1));
        rst_n = 1'b0; tick();
        rst_n = 1'b1;
        chk("R1 reset clears lines", irq_n, 7'h7F);
        chk("R1 reset clears cfg", cfg_rdata, 16'h0F00);
        tick();
        chk("R1 stays quiet at level 0", irq_n, 7'h7F);
        fifo_empty = 1'b1;
    endtask

    initial begin
        @(negedge clk); tick();
        rst_n = 1'b1;
        t_reset();
        t_fields();
        t_half_mode();
        t_nempty_mode();
        t_levels();
        t_reset_mid();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #(5.0 * 20000);
        n_run++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule